// File: doc/BRIEF.md
# Conveyor Part Diverter Sequencer

This block decides which parts on a conveyor get pushed off the line by a diverter actuator. A level sensor reports whether a part is sitting in front of it. The block synchronises that level to the clock, takes each rising edge as one new part, and counts parts in two counters that always advance together. The first counter opens a diversion window once it reaches its threshold. The second counter, which has the larger threshold, closes the window and sends both counters back to zero.

With the default thresholds of 6 and 11, a cycle covers eleven detected parts. Parts one to five pass. Parts six to ten are diverted for as long as each of them is present. The eleventh part is not diverted. It acts as the reset part, and the next part starts a new cycle at count one.

The actuator output depends on the live, synchronised sensor level. It drops as soon as a diverted part leaves, and it stays low in the cycle of a new detection, while the counters are still catching up.

Top module: `part_diverter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both counters clear and `divert_o` is low in the cycle that follows. After release, the next detected part is part one of a fresh cycle.
- R2: The sensor passes through a two-stage synchroniser. For a diverted part, `divert_o` goes high after the third rising edge that samples the sensor high, and not before. It goes low after the second rising edge that samples the sensor low.
- R3: One low-to-high transition of the synchronised sensor counts as exactly one part, however long the sensor then stays high.
- R4: Parts one through five of each cycle are never diverted.
- R5: Parts six through ten of each cycle are diverted while present. `divert_o` is low in the gap between two parts.
- R6: Part eleven is never diverted. In the cycle after the closing counter reaches its threshold, both counters are zero, so the following part is part one.
- R7: A reset in the middle of a cycle discards the partial count. A sensor that is already high when reset releases is taken as a new part one.
- R8: `divert_o` is never high while the synchronised sensor level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| part_sense_i | input | 1 | Asynchronous part-present level from the sensor |
| divert_o | output | 1 | Diverter actuator command, high to push the part off |

## Verification
Two things can land in the same cycle. One is the global reset and a fresh sensor rise. The other is the closing counter's wrap and the eleventh part still standing at the sensor. The bench asserts reset while the sensor is already high and releases it with the sensor held high. It then expects that part to count as part one and the later parts to follow the one-to-eleven numbering. The eleventh part is held high for many cycles, across the wrap, and `divert_o` is sampled both in the cycle the wrap is pending and after it. Random part and gap lengths, together with random mid-cycle resets, are compared against a bench-side part index.

// File: rtl/diverter_pkg.sv
// Package: diverter_pkg
// Shared defaults and a width helper for the part diverter.
// Assumes thresholds are small positive integers.
package diverter_pkg;
    localparam int unsigned DEF_WIN_OPEN    = 6;
    localparam int unsigned DEF_WIN_CLOSE   = 11;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Bits needed to hold values 0..maxval.
    function automatic int unsigned width_for(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction
endpackage

// File: rtl/sense_front.sv
// Module: sense_front
// Synchronises the asynchronous sensor level through STAGES flops and
// flags the cycle in which the synchronised level rises.
// Assumes STAGES >= 1 and a synchronous active-low reset.
module sense_front #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= raw_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~last_q;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R3
endmodule

// File: rtl/part_counter.sv
// Module: part_counter
// Saturating up-counter of detected parts with a synchronous clear
// that takes priority over an increment; done_o is high at or above PRESET.
// Assumes PRESET fits in W bits.
module part_counter #(
    parameter int unsigned PRESET = 6,
    parameter int unsigned W      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] count_o,
    output logic         done_o
);
    localparam logic [W-1:0] PRE_V = W'(PRESET);
    localparam logic [W-1:0] MAX_V = '1;

    // Count parts; clear wins, saturate at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                            count_o <= '0;
        else if (clr_i)                        count_o <= '0;
        else if (inc_i && (count_o != MAX_V))  count_o <= count_o + 1'b1;
    end

    assign done_o = (count_o >= PRE_V);

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0)); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(count_o)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && (count_o != MAX_V)) |=> (count_o == W'($past(count_o) + 1'b1))); // R3
endmodule

// File: rtl/part_diverter.sv
// Module: part_diverter
// Diverts parts WIN_OPEN .. WIN_CLOSE-1 of every cycle of WIN_CLOSE parts.
// Two counters advance on each detected part; the closing counter's done
// flag clears both one cycle later. The actuator follows the live
// synchronised level, masked in the detection cycle and while the wrap is pending.
// Assumes WIN_OPEN < WIN_CLOSE and a clean (debounced) sensor.
module part_diverter #(
    parameter int unsigned WIN_OPEN    = diverter_pkg::DEF_WIN_OPEN,
    parameter int unsigned WIN_CLOSE   = diverter_pkg::DEF_WIN_CLOSE,
    parameter int unsigned SYNC_STAGES = diverter_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic part_sense_i,
    output logic divert_o
);
    localparam int unsigned CNT_W = diverter_pkg::width_for(WIN_CLOSE);

    logic             level;
    logic             rise;
    logic [CNT_W-1:0] cnt_open;
    logic [CNT_W-1:0] cnt_close;
    logic             done_open;
    logic             done_close;

    sense_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (part_sense_i),
        .level_o (level),
        .rise_o  (rise)
    );

    part_counter #(.PRESET(WIN_OPEN), .W(CNT_W)) u_open (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (rise),
        .clr_i   (done_close),
        .count_o (cnt_open),
        .done_o  (done_open)
    );

    part_counter #(.PRESET(WIN_CLOSE), .W(CNT_W)) u_close (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (rise),
        .clr_i   (done_close),
        .count_o (cnt_close),
        .done_o  (done_close)
    );

    // Actuator: part present, window open, no pending wrap, count settled.
    always_comb begin
        divert_o = level & ~rise & done_open & ~done_close;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> ((cnt_close == '0) && (cnt_open == '0) && !divert_o)); // R1
    AST_TWIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_open == cnt_close); // R3
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_close <= CNT_W'(WIN_CLOSE)); // R6
    AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done_close |=> (!done_open && !divert_o)); // R6
    AST_DIVERT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        divert_o |-> level); // R8
    AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> !divert_o); // R2
endmodule

// File: tb/part_diverter_tb.sv
module part_diverter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic part_sense_i = 1'b0;
    logic divert_o;

    int checks = 0;
    int errors = 0;
    int part_no = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    part_diverter u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .part_sense_i (part_sense_i),
        .divert_o     (divert_o)
    );

    function automatic logic exp_divert(input int idx);
        return (idx >= 6) && (idx <= 10);
    endfunction

    function automatic int next_part(input int idx);
        return (idx >= 11) ? 1 : idx + 1;
    endfunction

    task automatic check(input logic exp, input string tag);
        checks++;
        if (divert_o !== exp) begin
            errors++;
            $display("FAIL %s: part %0d divert=%b expected %b", tag, part_no, divert_o, exp);
        end
    endtask

    // One part: high for hi cycles (>=3), then low for lo cycles (>=2).
    task automatic do_part(input int hi, input int lo);
        part_no = next_part(part_no);
        @(negedge clk) part_sense_i = 1'b1;
        repeat (2) @(negedge clk);
        check(1'b0, "R2 latency");
        @(negedge clk);
        if (part_no <= 5)       check(1'b0, "R4 pass");
        else if (part_no <= 10) check(1'b1, "R5 divert");
        else                    check(1'b0, "R6 reset part");
        repeat (hi - 3) @(negedge clk);
        if (hi > 6) check(exp_divert(part_no), "R3 long hold");
        part_sense_i = 1'b0;
        repeat (2) @(negedge clk);
        check(1'b0, "R5 gap");
        repeat (lo - 2) @(negedge clk);
    endtask

    task automatic do_reset(input logic sense_level);
        @(negedge clk);
        rst_n = 1'b0;
        part_sense_i = sense_level;
        repeat (2) @(negedge clk);
        check(1'b0, "R1 reset");
        rst_n = 1'b1;
        part_no = 0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        check(1'b0, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        // Directed: two full cycles with minimal timing.
        for (int i = 0; i < 22; i++) do_part(3, 2);
        // Directed: very long holds across the window, including part 11.
        for (int i = 0; i < 11; i++) do_part(20, 4);
        // R7: reset mid-cycle, with the sensor high across the release.
        for (int i = 0; i < 7; i++) do_part(4, 3);
        do_reset(1'b1);
        part_no = 1;
        repeat (4) @(negedge clk);
        check(1'b0, "R7 held part is part one");
        part_sense_i = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 12; i++) do_part(3, 3);
        // Random traffic, with occasional resets.
        for (int i = 0; i < 120; i++) begin
            if ($urandom_range(0, 19) == 0) begin
                do_reset(1'b0);
                @(negedge clk);
                check(1'b0, "R7 after reset");
            end
            do_part($urandom_range(3, 9), $urandom_range(2, 7));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule